// File: doc/BRIEF.md
# Prefix-Extended Immediate and Address Generator

This block sits in the decode/execute path of a 32-bit processor that has 16-bit instructions. An instruction word of that width has room for only a 5-bit immediate. A separate prefix instruction therefore supplies 11 further bits, which the block holds in a one-shot extension register. The next instruction consumes that register. The block merges the held bits with that instruction's short immediate. From the result it produces either a 32-bit immediate operand or a byte effective address for one of three memory addressing modes: register-direct, pointer-relative and stack-relative.

Decoded instructions arrive on a valid/ready stream. The decoder presents the operation class, the immediate fields, the pointer selector and a register index. The block then drives `rf_base_idx` combinationally, naming the register whose value must be read. The register file returns that value on `in_base` in the same cycle. Each accepted instruction other than a prefix yields one result beat on the output stream, held in a single register stage. An input beat is taken when `in_valid && in_ready`. `in_ready` is high whenever the output register is empty or is being drained in the same cycle (`out_ready` high). While `out_valid` is high and `out_ready` is low, the output beat is frozen and no input is taken. A prefix beat is accepted under the same rule but emits nothing.

Top module: `pfx_agu_top`

## Requirements
- R1: After an accepted prefix, the next accepted non-prefix instruction consumes the extension. Any instruction after that one sees no extension.
- R2: A prefix accepted while an extension is already pending replaces the held 11 bits. The next consumer uses only the newer value.
- R3: For class MOVI (`in_op`=2) and class ALUI (`in_op`=4), `out_imm` = the zero-extended 16-bit value {K[10:0], imm5[4:0]} when an extension is pending. Otherwise it is the zero-extended imm5. `out_addr` = 0.
- R4: For class MOVHI (`in_op`=3), `out_imm` = the same 16-bit value placed in bits 31..16, with bits 15..0 zero. `out_addr` = 0.
- R5: For class LDST (`in_op`=5), `rf_base_idx` = `in_rb_idx`. `out_addr` = base when no extension is pending, and base + 4 * sign-extended K when one is. `out_imm` = 0.
- R6: For class PTR (`in_op`=6), `rf_base_idx` = 16 + `in_ptr_sel`, so selectors 0..3 name r16..r19. Without an extension, `out_addr` = base + 4 * zero-extended imm5.
- R7: For class PTR with an extension pending, `out_addr` = base + 4 * sign-extension of the 16-bit value {K, imm5}.
- R8: For class STK (`in_op`=7), `rf_base_idx` = 14. `out_addr` = base + 4 * zero-extended `in_imm8`. A pending extension has no effect on this address but is still consumed.
- R9: For class PFX (`in_op`=1), the instruction emits no output beat. `in_ready` = !`out_valid` || `out_ready`. While `out_valid` is high and `out_ready` is low, `out_imm` and `out_addr` hold steady.
- R10: After reset, `out_valid` is low and no extension is pending.
- R11: For class NONE (`in_op`=0), the block emits a beat with `out_imm` = 0 and `out_addr` = 0, and consumes any pending extension.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction beat valid |
| in_ready | output | 1 | Instruction beat may be taken |
| in_op | input | 3 | Operation class (0 NONE, 1 PFX, 2 MOVI, 3 MOVHI, 4 ALUI, 5 LDST, 6 PTR, 7 STK) |
| in_imm11 | input | 11 | Prefix payload |
| in_imm5 | input | 5 | Short immediate of the instruction |
| in_imm8 | input | 8 | Stack word offset |
| in_ptr_sel | input | 2 | Pointer register selector |
| in_rb_idx | input | 5 | Base register index for LDST |
| rf_base_idx | output | 5 | Register index to read for the base value |
| in_base | input | 32 | Value of register `rf_base_idx` |
| out_valid | output | 1 | Result beat valid |
| out_ready | input | 1 | Result beat may be taken |
| out_imm | output | 32 | Formed immediate |
| out_addr | output | 32 | Byte effective address |

## Verification
The bench targets the sign boundary of the extension. It uses K = 0x7FF on a register-direct access and K = 0x400 on a pointer access. A design that zero-extended either value would produce an address far above the base instead of just below it. It checks that the extension disappears after exactly one consumer, including when the consumer is a stack access or a NONE instruction. A design that kept the extension would corrupt the next immediate, and one that skipped clearing on those classes would leak stale upper bits. It sends back-to-back prefixes to catch a design that merges or ignores the second one. It stalls the output to catch a beat that changes or an input that is accepted while the output is blocked.

// File: rtl/pfx_agu_pkg.sv
package pfx_agu_pkg;
  localparam int DATA_W   = 32;
  localparam int K_W      = 11;
  localparam int SIMM_W   = 5;
  localparam int STK_W    = 8;
  localparam int RIDX_W   = 5;
  localparam int PSEL_W   = 2;
  localparam int SCALE_SH = 2;
  localparam int SP_IDX   = 14;
  localparam int PTR_BASE = 16;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_PFX   = 3'd1,
    OP_MOVI  = 3'd2,
    OP_MOVHI = 3'd3,
    OP_ALUI  = 3'd4,
    OP_LDST  = 3'd5,
    OP_PTR   = 3'd6,
    OP_STK   = 3'd7
  } op_e;
endpackage

// File: rtl/pfx_kreg.sv
module pfx_kreg
  import pfx_agu_pkg::*;
#(
  parameter int KW = K_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  op_e           op,
  input  logic [KW-1:0] payload,
  output logic          pend,
  output logic [KW-1:0] kval
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= 1'b0;
      kval <= '0;
    end else if (fire) begin
      if (op == OP_PFX) begin
        pend <= 1'b1;
        kval <= payload;
      end else begin
        pend <= 1'b0;
      end
    end
  end

  assert_consume_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op != OP_PFX) |=> !pend);

  assert_pfx_overwrites_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op == OP_PFX) |=> (pend && kval == $past(payload)));
endmodule

// File: rtl/pfx_imm_build.sv
module pfx_imm_build
  import pfx_agu_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int KW = K_W,
  parameter int SW = SIMM_W
) (
  input  op_e           op,
  input  logic          pend,
  input  logic [KW-1:0] kval,
  input  logic [SW-1:0] imm5,
  output logic [DW-1:0] imm
);
  localparam int VW = KW + SW;
  localparam int HALF = DW / 2;

  logic [VW-1:0] merged;

  always_comb begin
    merged = pend ? {kval, imm5} : {{KW{1'b0}}, imm5};
    case (op)
      OP_MOVI, OP_ALUI: imm = {{(DW-VW){1'b0}}, merged};
      OP_MOVHI:         imm = {merged, {(HALF-(VW-HALF)-(HALF-VW+HALF-HALF)){1'b0}}} << 0;
      default:          imm = '0;
    endcase
  end
endmodule

// File: rtl/pfx_addr_gen.sv
module pfx_addr_gen
  import pfx_agu_pkg::*;
#(
  parameter int DW  = DATA_W,
  parameter int KW  = K_W,
  parameter int SW  = SIMM_W,
  parameter int TW  = STK_W,
  parameter int IW  = RIDX_W,
  parameter int PW  = PSEL_W,
  parameter int SH  = SCALE_SH
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          act,
  input  op_e           op,
  input  logic          pend,
  input  logic [KW-1:0] kval,
  input  logic [SW-1:0] imm5,
  input  logic [TW-1:0] imm8,
  input  logic [PW-1:0] psel,
  input  logic [IW-1:0] rb_idx,
  input  logic [DW-1:0] base,
  output logic [IW-1:0] base_idx,
  output logic [DW-1:0] ea
);
  localparam int VW = KW + SW;
  localparam logic [IW-1:0] SP_I = IW'(SP_IDX);
  localparam logic [IW-1:0] PB_I = IW'(PTR_BASE);

  logic [DW-1:0] k_sx, v_sx, i5_zx, i8_zx, words;

  always_comb begin
    k_sx  = {{(DW-KW){kval[KW-1]}}, kval};
    v_sx  = {{(DW-VW){kval[KW-1]}}, kval, imm5};
    i5_zx = {{(DW-SW){1'b0}}, imm5};
    i8_zx = {{(DW-TW){1'b0}}, imm8};
    base_idx = '0;
    words    = '0;
    case (op)
      OP_LDST: begin
        base_idx = rb_idx;
        words    = pend ? k_sx : '0;
      end
      OP_PTR: begin
        base_idx = PB_I + IW'(psel);
        words    = pend ? v_sx : i5_zx;
      end
      OP_STK: begin
        base_idx = SP_I;
        words    = i8_zx;
      end
      default: ;
    endcase
    if (op == OP_LDST || op == OP_PTR || op == OP_STK)
      ea = base + (words << SH);
    else
      ea = '0;
  end

  logic [DW-1:0] stk_delta;
  assign stk_delta = ea - base;

  assert_stack_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (act && op == OP_STK) |-> (stk_delta[SH-1:0] == '0 && stk_delta < (DW'(1) << (TW + SH))));

  assert_ptr_bank_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (act && op == OP_PTR) |-> (base_idx >= PB_I && base_idx < PB_I + IW'(1 << PW)));
endmodule

// File: rtl/pfx_out_stage.sv
module pfx_out_stage
  import pfx_agu_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] imm_d,
  input  logic [DW-1:0] ea_d,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [DW-1:0] out_imm,
  output logic [DW-1:0] out_addr,
  output logic          can_take
);
  assign can_take = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_imm   <= '0;
      out_addr  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_imm   <= imm_d;
      out_addr  <= ea_d;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assert_hold_when_stalled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_imm) && $stable(out_addr)));
endmodule

// File: rtl/pfx_agu_top.sv
module pfx_agu_top
  import pfx_agu_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int KW = K_W,
  parameter int SW = SIMM_W,
  parameter int TW = STK_W,
  parameter int IW = RIDX_W,
  parameter int PW = PSEL_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [2:0]    in_op,
  input  logic [KW-1:0] in_imm11,
  input  logic [SW-1:0] in_imm5,
  input  logic [TW-1:0] in_imm8,
  input  logic [PW-1:0] in_ptr_sel,
  input  logic [IW-1:0] in_rb_idx,
  output logic [IW-1:0] rf_base_idx,
  input  logic [DW-1:0] in_base,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_imm,
  output logic [DW-1:0] out_addr
);
  op_e           op;
  logic          fire, pend, emit;
  logic [KW-1:0] kval;
  logic [DW-1:0] imm_w, ea_w;

  assign op   = op_e'(in_op);
  assign fire = in_valid && in_ready;
  assign emit = fire && (op != OP_PFX);

  pfx_kreg #(.KW(KW)) u_kreg (
    .clk(clk), .rst_n(rst_n), .fire(fire), .op(op),
    .payload(in_imm11), .pend(pend), .kval(kval)
  );

  pfx_imm_build #(.DW(DW), .KW(KW), .SW(SW)) u_imm (
    .op(op), .pend(pend), .kval(kval), .imm5(in_imm5), .imm(imm_w)
  );

  pfx_addr_gen #(.DW(DW), .KW(KW), .SW(SW), .TW(TW), .IW(IW), .PW(PW), .SH(SCALE_SH)) u_ag (
    .clk(clk), .rst_n(rst_n), .act(in_valid), .op(op), .pend(pend), .kval(kval),
    .imm5(in_imm5), .imm8(in_imm8), .psel(in_ptr_sel), .rb_idx(in_rb_idx),
    .base(in_base), .base_idx(rf_base_idx), .ea(ea_w)
  );

  pfx_out_stage #(.DW(DW)) u_out (
    .clk(clk), .rst_n(rst_n), .load(emit), .imm_d(imm_w), .ea_d(ea_w),
    .out_ready(out_ready), .out_valid(out_valid), .out_imm(out_imm),
    .out_addr(out_addr), .can_take(in_ready)
  );

  assert_pfx_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op == OP_PFX && out_ready) |=> !out_valid);

  assert_stall_blocks_input_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
endmodule

// File: tb/pfx_agu_tb_top.sv
module pfx_agu_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  in_op = '0;
  logic [10:0] in_imm11 = '0;
  logic [4:0]  in_imm5 = '0;
  logic [7:0]  in_imm8 = '0;
  logic [1:0]  in_ptr_sel = '0;
  logic [4:0]  in_rb_idx = '0;
  logic [4:0]  rf_base_idx;
  logic [31:0] in_base = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_imm, out_addr;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pfx_agu_top dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_imm11(in_imm11), .in_imm5(in_imm5), .in_imm8(in_imm8),
    .in_ptr_sel(in_ptr_sel), .in_rb_idx(in_rb_idx), .rf_base_idx(rf_base_idx),
    .in_base(in_base), .out_valid(out_valid), .out_ready(out_ready),
    .out_imm(out_imm), .out_addr(out_addr)
  );

  typedef struct packed {
    logic [2:0]  op;
    logic [10:0] k;
    logic [4:0]  i5;
    logic [7:0]  i8;
    logic [1:0]  sel;
    logic [4:0]  rb;
    logic [31:0] base;
    logic        emit;
    logic [31:0] eimm;
    logic [31:0] eaddr;
    logic [4:0]  eidx;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t TBL [NV] = '{
    '{3'd2, 11'h000, 5'h1F, 8'h00, 2'd0, 5'd0,  32'h55,      1'b1, 32'h0000001F, 32'h0,        5'd0},  // R3 plain
    '{3'd1, 11'h003, 5'h00, 8'h00, 2'd0, 5'd0,  32'h0,       1'b0, 32'h0,        32'h0,        5'd0},  // R9 pfx
    '{3'd2, 11'h000, 5'h04, 8'h00, 2'd0, 5'd0,  32'h55,      1'b1, 32'h00000064, 32'h0,        5'd0},  // R3 merged
    '{3'd2, 11'h000, 5'h01, 8'h00, 2'd0, 5'd0,  32'h0,       1'b1, 32'h00000001, 32'h0,        5'd0},  // R1 consumed
    '{3'd1, 11'h7FF, 5'h00, 8'h00, 2'd0, 5'd0,  32'h0,       1'b0, 32'h0,        32'h0,        5'd0},
    '{3'd3, 11'h000, 5'h1F, 8'h00, 2'd0, 5'd0,  32'h0,       1'b1, 32'hFFFF0000, 32'h0,        5'd0},  // R4 merged
    '{3'd3, 11'h000, 5'h02, 8'h00, 2'd0, 5'd0,  32'h0,       1'b1, 32'h00020000, 32'h0,        5'd0},  // R4 plain
    '{3'd5, 11'h000, 5'h00, 8'h00, 2'd0, 5'd17, 32'h4,       1'b1, 32'h0,        32'h4,        5'd17}, // R5 plain
    '{3'd1, 11'h007, 5'h00, 8'h00, 2'd0, 5'd0,  32'h0,       1'b0, 32'h0,        32'h0,        5'd0},
    '{3'd5, 11'h000, 5'h00, 8'h00, 2'd0, 5'd19, 32'h8,       1'b1, 32'h0,        32'h24,       5'd19}, // R5 offset
    '{3'd1, 11'h7FF, 5'h00, 8'h00, 2'd0, 5'd0,  32'h0,       1'b0, 32'h0,        32'h0,        5'd0},
    '{3'd5, 11'h000, 5'h00, 8'h00, 2'd0, 5'd3,  32'h100,     1'b1, 32'h0,        32'hFC,       5'd3},  // R5 negative
    '{3'd6, 11'h000, 5'h03, 8'h00, 2'd0, 5'd0,  32'h20,      1'b1, 32'h0,        32'h2C,       5'd16}, // R6
    '{3'd1, 11'h003, 5'h00, 8'h00, 2'd0, 5'd0,  32'h0,       1'b0, 32'h0,        32'h0,        5'd0},
    '{3'd6, 11'h000, 5'h04, 8'h00, 2'd3, 5'd0,  32'h20,      1'b1, 32'h0,        32'h1B0,      5'd19}, // R7
    '{3'd1, 11'h400, 5'h00, 8'h00, 2'd0, 5'd0,  32'h0,       1'b0, 32'h0,        32'h0,        5'd0},
    '{3'd6, 11'h000, 5'h00, 8'h00, 2'd1, 5'd0,  32'h40000,   1'b1, 32'h0,        32'h20000,    5'd17}, // R7 negative
    '{3'd1, 11'h7FF, 5'h00, 8'h00, 2'd0, 5'd0,  32'h0,       1'b0, 32'h0,        32'h0,        5'd0},
    '{3'd7, 11'h000, 5'h1F, 8'hFF, 2'd0, 5'd0,  32'h1000,    1'b1, 32'h0,        32'h13FC,     5'd14}, // R8 ignores K
    '{3'd2, 11'h000, 5'h02, 8'h00, 2'd0, 5'd0,  32'h0,       1'b1, 32'h00000002, 32'h0,        5'd0},  // R8 consumed
    '{3'd1, 11'h005, 5'h00, 8'h00, 2'd0, 5'd0,  32'h0,       1'b0, 32'h0,        32'h0,        5'd0},
    '{3'd1, 11'h009, 5'h00, 8'h00, 2'd0, 5'd0,  32'h0,       1'b0, 32'h0,        32'h0,        5'd0},
    '{3'd2, 11'h000, 5'h00, 8'h00, 2'd0, 5'd0,  32'h0,       1'b1, 32'h00000120, 32'h0,        5'd0},  // R2
    '{3'd1, 11'h005, 5'h00, 8'h00, 2'd0, 5'd0,  32'h0,       1'b0, 32'h0,        32'h0,        5'd0},
    '{3'd0, 11'h000, 5'h07, 8'h00, 2'd0, 5'd0,  32'h77,      1'b1, 32'h0,        32'h0,        5'd0},  // R11
    '{3'd2, 11'h000, 5'h01, 8'h00, 2'd0, 5'd0,  32'h0,       1'b1, 32'h00000001, 32'h0,        5'd0},  // R11 consumed
    '{3'd1, 11'h400, 5'h00, 8'h00, 2'd0, 5'd0,  32'h0,       1'b0, 32'h0,        32'h0,        5'd0},
    '{3'd4, 11'h000, 5'h01, 8'h00, 2'd0, 5'd0,  32'h0,       1'b1, 32'h00008001, 32'h0,        5'd0}   // R3 alu
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    in_valid   = 1'b1;
    in_op      = v.op;
    in_imm11   = v.k;
    in_imm5    = v.i5;
    in_imm8    = v.i8;
    in_ptr_sel = v.sel;
    in_rb_idx  = v.rb;
    in_base    = v.base;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    vec_t v;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk("R10 out_valid after reset", {31'b0, out_valid}, 32'h0);
    chk("R10 in_ready after reset", {31'b0, in_ready}, 32'h1);

    for (int i = 0; i < NV; i++) begin
      drive(TBL[i]);
      #1;
      if (TBL[i].op >= 3'd5)
        chk($sformatf("R5/R6/R8 base index row %0d", i), {27'b0, rf_base_idx}, {27'b0, TBL[i].eidx});
      @(negedge clk);
      chk($sformatf("R9 out_valid row %0d", i), {31'b0, out_valid}, {31'b0, TBL[i].emit});
      if (TBL[i].emit) begin
        chk($sformatf("R3/R4/R11 imm row %0d", i), out_imm, TBL[i].eimm);
        chk($sformatf("R5/R6/R7/R8 addr row %0d", i), out_addr, TBL[i].eaddr);
      end
    end
    in_valid = 1'b0;
    @(negedge clk);

    // R10: a prefix pending at reset is dropped
    v = TBL[1];
    drive(v);
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    chk("R10 out_valid low after mid-run reset", {31'b0, out_valid}, 32'h0);
    v = TBL[3];
    drive(v);
    @(negedge clk);
    chk("R10 no extension after reset", out_imm, 32'h00000001);

    // R9: back-pressure
    in_valid = 1'b0;
    @(negedge clk);
    out_ready = 1'b0;
    v = TBL[0];
    v.i5 = 5'h05;
    drive(v);
    @(negedge clk);
    chk("R9 first beat taken", out_imm, 32'h00000005);
    v = TBL[6];
    v.i5 = 5'h01;
    drive(v);
    #1;
    chk("R9 in_ready low while stalled", {31'b0, in_ready}, 32'h0);
    @(negedge clk);
    chk("R9 beat held while stalled", out_imm, 32'h00000005);
    chk("R9 valid held while stalled", {31'b0, out_valid}, 32'h1);
    out_ready = 1'b1;
    #1;
    chk("R9 in_ready on drain", {31'b0, in_ready}, 32'h1);
    @(negedge clk);
    chk("R9 next beat after drain", out_imm, 32'h00010000);
    in_valid = 1'b0;
    @(negedge clk);
    chk("R9 output empties", {31'b0, out_valid}, 32'h0);

    done = 1'b1;
    finish_run();
  end
endmodule